// File: doc/BRIEF.md
# Special Register Move Unit

This unit carries values between a general-purpose register file and three special registers: the fixed-point exception register (XER, 32 bits), the link register (LR, 64 bits) and the count register (CTR, 64 bits). It accepts one 32-bit instruction word per cycle. It recognizes two forms: a move-from, which copies a special register into a GPR, and a move-to, which copies a GPR into a special register.

The 10-bit special-register field of the word is stored with its two 5-bit halves exchanged. The unit rebuilds the register number before it selects a register. The value from a move-from leaves through a registered write-back port one cycle later. A move-to changes the special register at the clock edge. An unsupported register number raises a one-cycle illegal flag and leaves every register untouched.

Top module: `spr_move_unit`

## Requirements
- R1: After synchronous active-high reset, `wb_valid`, `illegal`, `wb_idx` and `wb_data` are zero, and all three special registers read back as zero.
- R2: With field f = `in_word[20:11]`, the register number is n = {f[4:0], f[9:5]}. n = 1 selects XER, n = 8 selects LR and n = 9 selects CTR.
- R3: A word is recognized only when `in_word[31:26]` = 31 and `in_word[10:1]` is 339 (move-from) or 467 (move-to). Bit 0 is ignored. Any other word changes no register and produces no write-back and no illegal flag.
- R4: A recognized move-from of a supported n sets `wb_valid` high one cycle later. In that cycle `wb_idx` = `in_word[25:21]` and `wb_data` = the register value before that edge. In every cycle without a write-back, `wb_idx` and `wb_data` are zero.
- R5: A recognized move-to of a supported n stores `rs_data` into the selected register at the clock edge. A move-from issued in the next cycle returns the new value. The move-to itself produces no write-back.
- R6: XER keeps only `rs_data[31:0]` on a write. It reads back zero-extended, so bits 63:32 of `wb_data` are zero.
- R7: A recognized move-from or move-to whose n is not 1, 8 or 9 sets `illegal` high for the following cycle. It produces no write-back and changes no special register.
- R8: While `in_valid` is low, the word has no effect.
- R9: `rs_idx` combinationally equals `in_word[25:21]`. It addresses the GPR read port whose data arrives on `rs_data` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| in_word | input | 32 | Instruction word |
| rs_idx | output | 5 | GPR read address for a move-to source |
| rs_data | input | 64 | GPR read data for `rs_idx` |
| wb_valid | output | 1 | Registered GPR write-back strobe |
| wb_idx | output | 5 | Registered destination GPR index |
| wb_data | output | 64 | Registered write-back value |
| illegal | output | 1 | Registered unsupported-register flag |

## Verification
The assertions rely on `rs_data` being a stable, defined value whenever `in_valid` is high. They also rely on reset being held for at least one clock before the first word. The bench drives every input at the falling edge and holds reset for several cycles, which keeps both conditions true. It sweeps all 1024 values of the special-register field through a move-to followed by a move-from. It mixes in unrecognized opcodes, invalid cycles and words with bit 0 set. It compares every cycle against an arithmetic model of the three registers.

// File: rtl/spr_move_pkg.sv
package spr_move_pkg;
  localparam logic [5:0] OPC_MAIN  = 6'd31;
  localparam logic [9:0] XO_FROM   = 10'd339;
  localparam logic [9:0] XO_TO     = 10'd467;
  localparam logic [9:0] NUM_XER   = 10'd1;
  localparam logic [9:0] NUM_LR    = 10'd8;
  localparam logic [9:0] NUM_CTR   = 10'd9;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_XER  = 2'd1,
    SEL_LR   = 2'd2,
    SEL_CTR  = 2'd3
  } spr_sel_e;
endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_move_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5,
  parameter int FLD_W  = 10
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output logic              is_from,
  output logic              is_to,
  output spr_sel_e          sel,
  output logic [IDX_W-1:0]  gidx
);
  localparam int HALF = FLD_W / 2;

  logic [FLD_W-1:0] fld;
  logic [FLD_W-1:0] num;
  logic             prim_ok;

  assign fld     = word[20:11];
  assign num     = {fld[HALF-1:0], fld[FLD_W-1:HALF]};
  assign gidx    = word[25:21];
  assign prim_ok = valid && (word[31:26] == OPC_MAIN);
  assign is_from = prim_ok && (word[10:1] == XO_FROM);
  assign is_to   = prim_ok && (word[10:1] == XO_TO);

  always_comb begin
    unique case (num)
      NUM_XER: sel = SEL_XER;
      NUM_LR:  sel = SEL_LR;
      NUM_CTR: sel = SEL_CTR;
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/spr_regs.sv
module spr_regs
  import spr_move_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int XER_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  spr_sel_e        wsel,
  input  logic [XLEN-1:0] wdata,
  input  spr_sel_e        rsel,
  output logic [XLEN-1:0] rdata,
  output logic [XER_W-1:0] xer_q,
  output logic [XLEN-1:0] lr_q,
  output logic [XLEN-1:0] ctr_q
);
  logic [XLEN-1:0] xer_ext;

  generate
    if (XER_W < XLEN) begin : g_zext
      assign xer_ext = {{(XLEN-XER_W){1'b0}}, xer_q};
    end else begin : g_full
      assign xer_ext = xer_q[XLEN-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      xer_q <= '0;
      lr_q  <= '0;
      ctr_q <= '0;
    end else if (we) begin
      case (wsel)
        SEL_XER: xer_q <= wdata[XER_W-1:0];
        SEL_LR:  lr_q  <= wdata;
        SEL_CTR: ctr_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rsel)
      SEL_XER: rdata = xer_ext;
      SEL_LR:  rdata = lr_q;
      SEL_CTR: rdata = ctr_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/spr_wb_stage.sv
module spr_wb_stage
  import spr_move_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             is_from,
  input  logic             is_to,
  input  spr_sel_e         sel,
  input  logic [IDX_W-1:0] gidx,
  input  logic [XLEN-1:0]  rdata,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]  wb_data,
  output logic             illegal
);
  logic hit;
  assign hit = is_from && (sel != SEL_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
      illegal  <= 1'b0;
    end else begin
      wb_valid <= hit;
      wb_idx   <= hit ? gidx : '0;
      wb_data  <= hit ? rdata : '0;
      illegal  <= (is_from || is_to) && (sel == SEL_NONE);
    end
  end
endmodule

// File: rtl/spr_move_unit.sv
module spr_move_unit
  import spr_move_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int XER_W  = 32,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic [IDX_W-1:0]  rs_idx,
  input  logic [XLEN-1:0]   rs_data,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [XLEN-1:0]   wb_data,
  output logic              illegal
);
  logic             is_from;
  logic             is_to;
  spr_sel_e         sel;
  logic [IDX_W-1:0] gidx;
  logic [XLEN-1:0]  rdata;
  logic [XER_W-1:0] xer_q;
  logic [XLEN-1:0]  lr_q;
  logic [XLEN-1:0]  ctr_q;

  assign rs_idx = gidx;

  spr_decode #(.WORD_W(WORD_W), .IDX_W(IDX_W), .FLD_W(10)) u_dec (
    .valid   (in_valid),
    .word    (in_word),
    .is_from (is_from),
    .is_to   (is_to),
    .sel     (sel),
    .gidx    (gidx)
  );

  spr_regs #(.XLEN(XLEN), .XER_W(XER_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (is_to),
    .wsel  (sel),
    .wdata (rs_data),
    .rsel  (sel),
    .rdata (rdata),
    .xer_q (xer_q),
    .lr_q  (lr_q),
    .ctr_q (ctr_q)
  );

  spr_wb_stage #(.XLEN(XLEN), .IDX_W(IDX_W)) u_wb (
    .clk      (clk),
    .rst      (rst),
    .is_from  (is_from),
    .is_to    (is_to),
    .sel      (sel),
    .gidx     (gidx),
    .rdata    (rdata),
    .wb_valid (wb_valid),
    .wb_idx   (wb_idx),
    .wb_data  (wb_data),
    .illegal  (illegal)
  );
endmodule

// File: rtl/spr_move_unit_chk.sv
module spr_move_unit_chk #(
  parameter int XLEN   = 64,
  parameter int XER_W  = 32,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word,
  input logic              wb_valid,
  input logic [IDX_W-1:0]  wb_idx,
  input logic [XLEN-1:0]   wb_data,
  input logic              illegal,
  input logic [XER_W-1:0]  xer_q,
  input logic [XLEN-1:0]   lr_q,
  input logic [XLEN-1:0]   ctr_q
);
  logic from_word;
  logic to_word;
  assign from_word = in_valid && (in_word[31:26] == 6'd31) && (in_word[10:1] == 10'd339);
  assign to_word   = in_valid && (in_word[31:26] == 6'd31) && (in_word[10:1] == 10'd467);

  // R7
  illegal_keeps_regs_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($stable(xer_q) && $stable(lr_q) && $stable(ctr_q)));

  // R7
  illegal_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wb_valid);

  // R8
  no_write_without_to_chk: assert property (@(posedge clk) disable iff (rst)
    !to_word |=> ($stable(xer_q) && $stable(lr_q) && $stable(ctr_q)));

  // R4
  wb_needs_from_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(from_word));

  // R4
  wb_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !wb_valid |-> (wb_data == '0 && wb_idx == '0));

  // R6
  xer_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (from_word && in_word[20:11] == 10'h020) |=> (wb_data[XLEN-1:XER_W] == '0));
endmodule

bind spr_move_unit spr_move_unit_chk #(
  .XLEN(XLEN), .XER_W(XER_W), .WORD_W(WORD_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/spr_move_unit_tb.sv
module spr_move_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [4:0]  rs_idx;
  logic [63:0] rs_data = '0;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;
  logic        illegal;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] m_xer = '0;
  logic [63:0] m_lr = '0;
  logic [63:0] m_ctr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spr_move_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .rs_idx(rs_idx), .rs_data(rs_data), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data), .illegal(illegal)
  );

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [9:0] xo, input logic [4:0] idx, input logic [9:0] n);
    return {6'd31, idx, n[4:0], n[9:5], xo, 1'b0};
  endfunction

  // One cycle: drive at falling edge, let one rising edge pass, compare at next falling edge.
  task automatic step(input bit v, input logic [31:0] w, input logic [63:0] d, input string req);
    logic        recog, from_op, to_op, known;
    logic [9:0]  n;
    logic [63:0] cur;
    logic [71:0] exp, act;
    in_valid = v; in_word = w; rs_data = d;
    #1;
    check(rs_idx == w[25:21], "R9", {67'd0, rs_idx}, {67'd0, w[25:21]});
    recog   = v && (w[31:26] == 6'd31);
    from_op = recog && (w[10:1] == 10'd339);
    to_op   = recog && (w[10:1] == 10'd467);
    n       = {w[15:11], w[20:16]};
    known   = (n == 10'd1) || (n == 10'd8) || (n == 10'd9);
    cur     = (n == 10'd1) ? {32'd0, m_xer} : (n == 10'd8) ? m_lr : (n == 10'd9) ? m_ctr : 64'd0;
    exp = {from_op && known, (from_op || to_op) && !known,
           (from_op && known) ? w[25:21] : 5'd0, (from_op && known) ? cur : 64'd0};
    if (to_op && known) begin
      if (n == 10'd1) m_xer = d[31:0];
      else if (n == 10'd8) m_lr = d;
      else m_ctr = d;
    end
    @(negedge clk);
    act = {wb_valid, illegal, wb_idx, wb_data};
    check(act == exp, req, act, exp);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state of outputs, then every register reads zero
    check({wb_valid, illegal, wb_idx, wb_data} == '0, "R1",
          {wb_valid, illegal, wb_idx, wb_data}, 72'd0);
    step(1, mk(10'd339, 5'd3, 10'd1), 64'hFFFF, "R1");
    step(1, mk(10'd339, 5'd4, 10'd8), 64'hFFFF, "R1");
    step(1, mk(10'd339, 5'd5, 10'd9), 64'hFFFF, "R1");

    // R2 R4 R5 R6 R7: sweep every encoded field through move-to then move-from
    for (int f = 0; f < 1024; f++) begin
      logic [9:0]  fv;
      logic [9:0]  nn;
      logic [63:0] d;
      fv = f[9:0];
      nn = {fv[4:0], fv[9:5]};
      d  = {fv, 22'h15A3C7, ~fv, 22'h3C0F1E};
      step(1, mk(10'd467, fv[4:0], nn), d, "R5_R7");
      step(1, mk(10'd339, ~fv[4:0], nn), ~d, "R2_R4_R6");
    end

    // R6: XER upper half dropped on write
    step(1, mk(10'd467, 5'd1, 10'd1), 64'hDEADBEEF_12345678, "R6");
    step(1, mk(10'd339, 5'd2, 10'd1), 64'd0, "R6");

    // R3: wrong opcode / extended code change nothing, readback confirms
    step(1, {6'd30, 5'd1, 5'd8, 5'd0, 10'd467, 1'b0}, 64'h1111, "R3");
    step(1, mk(10'd466, 5'd1, 10'd8), 64'h2222, "R3");
    step(1, mk(10'd338, 5'd1, 10'd9), 64'h3333, "R3");
    step(1, mk(10'd339, 5'd7, 10'd8), 64'd0, "R3");
    step(1, mk(10'd339, 5'd7, 10'd9), 64'd0, "R3");
    // R3: bit 0 ignored
    step(1, mk(10'd467, 5'd1, 10'd8) | 32'd1, 64'hA5A5_0000_FFFF_1234, "R3");
    step(1, mk(10'd339, 5'd9, 10'd8) | 32'd1, 64'd0, "R3");

    // R8: invalid cycles have no effect
    step(0, mk(10'd467, 5'd1, 10'd9), 64'h7777, "R8");
    step(0, mk(10'd339, 5'd1, 10'd9), 64'h7777, "R8");
    step(1, mk(10'd339, 5'd1, 10'd9), 64'd0, "R8");

    // R5: back-to-back writes, each immediately read back
    for (int k = 0; k < 8; k++) begin
      step(1, mk(10'd467, 5'd2, 10'd9), 64'h0101_0101_0101_0101 * (k + 1), "R5");
      step(1, mk(10'd339, 5'(k), 10'd9), 64'd0, "R5");
    end

    step(0, 32'd0, 64'd0, "R8");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule